// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery

This block takes the demodulated bit stream of an FSK receiver and brings back both the bit timing and the bit values. The raw data is sampled on a strobe that runs at a fixed multiple of the bit rate. By default that multiple is 29, which puts the top rate near 115 kbit/s. A phase counter is kept in step with the transitions it observes. Each bit is emitted once per bit period, together with a one-cycle bit strobe. The value comes from a three-sample vote around the bit centre.

The phase loop can track in a fast mode or a slow mode. Fast mode uses large corrections and settles quickly. Slow mode uses unit corrections, so it resists noise better, but it needs cleaner input timing. An automatic mode runs fast until lock is reached, then runs slow. If lock is lost, it returns to fast. A lock flag reports a run of on-time transitions. A separate quality detector counts short runs (spikes) in the raw data over a window of bit periods. It compares that count with a 3-bit threshold to report whether a real transmitter is present.

Top module: `crc_clock_recovery`

## Requirements
- R1: While reset is asserted and just after it is released, `rx_bit`, `bit_stb`, `locked` and `dq_ok` are all 0.
- R2: With no transitions on `raw_in`, `bit_stb` pulses for one clock once every 29 sample strobes. The first pulse follows the 16th sample strobe after reset, and `bit_stb` is never high unless a sample strobe occurred on the previous clock.
- R3: At each `bit_stb`, `rx_bit` equals the majority of the last three raw samples: the one taken at the strobe and the two before it. `rx_bit` changes at no other time.
- R4: The phase position is 0 at the first sample after reset and advances by one per sample modulo 29. Mode code 0 (fast): a transition seen at position e in 1..14 pulls the next position back by min(3, e). One seen at e in 15..28 pushes it forward by min(3, 29-e). An on-time transition therefore gives a strobe 15 samples after it.
- R5: Mode code 1 (slow) applies the same rule with a correction of min(1, error).
- R6: Mode codes 2 and 3 (automatic) correct by 1 while `locked` is high and by 3 while it is low, so lock loss returns the loop to fast tracking.
- R7: `locked` rises on the 8th consecutive transition seen at position 0..2 or 27..28, and falls on any transition seen at another position.
- R8: A spike is a run of equal raw samples shorter than 7 samples that ends in a transition. A run of exactly 7 is not a spike.
- R9: At every 16th `bit_stb`, `dq_ok` is set to 1 if the spikes counted in that window are at most `cfg_dq_thresh`, and to 0 otherwise. It holds between windows and is 0 until the first window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Oversampling strobe, one clock wide, at 29 times the bit rate |
| raw_in | input | 1 | Raw demodulated data |
| cfg_mode | input | 2 | Tracking mode: 0 fast, 1 slow, 2 or 3 automatic |
| cfg_dq_thresh | input | 3 | Largest spike count per window still judged valid |
| rx_bit | output | 1 | Recovered data bit |
| bit_stb | output | 1 | One-cycle strobe marking a new `rx_bit` |
| locked | output | 1 | Phase lock flag |
| dq_ok | output | 1 | Data quality valid flag |

## Verification
The bench builds the block with its defaults: 29 samples per bit, centre sample 14, corrections of 3 and 1, a tolerance of 2, eight edges to lock, spikes under 7 samples, and a 16-bit window. With these values, single stretched or shortened bits produce strobe offsets the bench can predict exactly (11 to 19 samples). The same holds for the offsets in the bit that follows. This makes each tracking mode, the switch back after lock loss, and both sides of the tolerance edge visible at the ports. Pulses of 6 and 7 samples at bit ends place the spike length boundary and the threshold comparison inside the first quality window.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    TRK_FAST = 2'd0,
    TRK_SLOW = 2'd1,
    TRK_AUTO = 2'd2,
    TRK_AUTO_ALT = 2'd3
  } trk_mode_e;

  // Three-input majority used for the centre vote (R3)
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Next phase position after one sample, with edge correction (R4, R5)
  function automatic int unsigned phase_next(input int unsigned ph, input int unsigned osr,
                                             input int unsigned step, input logic edge_hit);
    int unsigned adj;
    int unsigned nxt;
    adj = 0;
    if (!edge_hit || ph == 0) begin
      nxt = ph + 1;
    end else if (ph <= osr / 2) begin
      adj = (step < ph) ? step : ph;
      nxt = ph + 1 - adj;
    end else begin
      adj = (step < osr - ph) ? step : osr - ph;
      nxt = ph + 1 + adj;
    end
    if (nxt >= osr) nxt = nxt - osr;
    return nxt;
  endfunction

  // Edge counts as on time when within tol of the boundary (R7)
  function automatic logic in_window(input int unsigned ph, input int unsigned osr,
                                     input int unsigned tol);
    return (ph <= tol) || (ph >= osr - tol);
  endfunction

  // Correction size chosen by mode and lock state (R6)
  function automatic int unsigned pick_step(input logic [1:0] mode, input logic lock_now,
                                            input int unsigned fast, input int unsigned slow);
    int unsigned s;
    case (trk_mode_e'(mode))
      TRK_FAST: s = fast;
      TRK_SLOW: s = slow;
      default:  s = lock_now ? slow : fast;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/crc_edge_front.sv
module crc_edge_front #(
  parameter int unsigned SPIKE_LEN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       raw_in,
  output logic [1:0] prev_smp,
  output logic       edge_seen,
  output logic       spike_hit
);
  localparam int unsigned RUN_W = $clog2(SPIKE_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SPIKE_LEN);

  logic [RUN_W-1:0] run_q;

  assign edge_seen = sample_en && (raw_in != prev_smp[0]);
  // R8: the run that ends here was shorter than SPIKE_LEN
  assign spike_hit = edge_seen && (run_q < RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_smp <= '0;
      run_q    <= RUN_MAX;
    end else if (sample_en) begin
      prev_smp <= {prev_smp[0], raw_in};
      if (edge_seen)            run_q <= RUN_W'(1);
      else if (run_q != RUN_MAX) run_q <= run_q + RUN_W'(1);
    end
  end
endmodule

// File: rtl/crc_phase_track.sv
module crc_phase_track
  import crc_pkg::*;
#(
  parameter int unsigned OSR    = 29,
  parameter int unsigned CENTER = 14,
  parameter int unsigned PH_W   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic            raw_in,
  input  logic [1:0]      prev_smp,
  input  logic            edge_seen,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] ph_q,
  output logic            center_hit,
  output logic            rx_bit,
  output logic            bit_stb
);
  localparam logic [PH_W-1:0] VOTE_PH = PH_W'(CENTER + 1);

  logic [PH_W-1:0] ph_d;

  assign center_hit = sample_en && (ph_q == VOTE_PH);
  assign ph_d = PH_W'(phase_next(32'(ph_q), OSR, 32'(step), edge_seen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      rx_bit  <= 1'b0;
      bit_stb <= 1'b0;
    end else begin
      bit_stb <= center_hit;
      if (sample_en) ph_q <= ph_d;
      if (center_hit) rx_bit <= vote3(prev_smp[1], prev_smp[0], raw_in);
    end
  end
endmodule

// File: rtl/crc_lock_det.sv
module crc_lock_det
  import crc_pkg::*;
#(
  parameter int unsigned OSR        = 29,
  parameter int unsigned LOCK_TOL   = 2,
  parameter int unsigned LOCK_EDGES = 8,
  parameter int unsigned PH_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_seen,
  input  logic [PH_W-1:0] ph_q,
  output logic            edge_good,
  output logic            locked
);
  localparam int unsigned CNT_W = $clog2(LOCK_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LOCK_EDGES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_EDGES - 1);

  logic [CNT_W-1:0] good_q;

  assign edge_good = edge_seen && in_window(32'(ph_q), OSR, LOCK_TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      locked <= 1'b0;
    end else if (edge_seen) begin
      if (edge_good) begin
        if (good_q != CNT_MAX) good_q <= good_q + CNT_W'(1);
        locked <= locked || (good_q >= CNT_LAST);
      end else begin
        good_q <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_dq_det.sv
module crc_dq_det #(
  parameter int unsigned WIN_BITS = 16,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned TH_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spike_hit,
  input  logic            center_hit,
  input  logic [TH_W-1:0] thresh,
  output logic            win_done,
  output logic            dq_ok
);
  localparam int unsigned WIN_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_BITS - 1);
  localparam logic [CNT_W-1:0] SPK_MAX  = '1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] spk_q;
  logic [CNT_W-1:0] spk_sum;

  assign win_done = center_hit && (win_q == WIN_LAST);
  assign spk_sum  = (spike_hit && spk_q != SPK_MAX) ? spk_q + CNT_W'(1) : spk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      spk_q <= '0;
      dq_ok <= 1'b0;
    end else begin
      if (center_hit) win_q <= win_done ? '0 : win_q + WIN_W'(1);
      if (win_done) begin
        dq_ok <= (spk_sum <= CNT_W'(thresh));
        spk_q <= '0;
      end else begin
        spk_q <= spk_sum;
      end
    end
  end
endmodule

// File: rtl/crc_clock_recovery.sv
module crc_clock_recovery
  import crc_pkg::*;
#(
  parameter int unsigned OSR        = 29,
  parameter int unsigned CENTER     = 14,
  parameter int unsigned FAST_STEP  = 3,
  parameter int unsigned SLOW_STEP  = 1,
  parameter int unsigned LOCK_TOL   = 2,
  parameter int unsigned LOCK_EDGES = 8,
  parameter int unsigned SPIKE_LEN  = 7,
  parameter int unsigned WIN_BITS   = 16,
  parameter int unsigned SPK_W      = 5,
  parameter int unsigned TH_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic            raw_in,
  input  logic [1:0]      cfg_mode,
  input  logic [TH_W-1:0] cfg_dq_thresh,
  output logic            rx_bit,
  output logic            bit_stb,
  output logic            locked,
  output logic            dq_ok
);
  localparam int unsigned PH_W = $clog2(OSR);

  logic [1:0]      prev_smp;
  logic            edge_seen;
  logic            spike_hit;
  logic            edge_good;
  logic            center_hit;
  logic            win_done;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] step_sel;

  assign step_sel = PH_W'(pick_step(cfg_mode, locked, FAST_STEP, SLOW_STEP));

  crc_edge_front #(.SPIKE_LEN(SPIKE_LEN)) u_front (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .raw_in(raw_in),
    .prev_smp(prev_smp), .edge_seen(edge_seen), .spike_hit(spike_hit)
  );

  crc_phase_track #(.OSR(OSR), .CENTER(CENTER), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .raw_in(raw_in),
    .prev_smp(prev_smp), .edge_seen(edge_seen), .step(step_sel),
    .ph_q(ph_q), .center_hit(center_hit), .rx_bit(rx_bit), .bit_stb(bit_stb)
  );

  crc_lock_det #(.OSR(OSR), .LOCK_TOL(LOCK_TOL), .LOCK_EDGES(LOCK_EDGES), .PH_W(PH_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .ph_q(ph_q),
    .edge_good(edge_good), .locked(locked)
  );

  crc_dq_det #(.WIN_BITS(WIN_BITS), .CNT_W(SPK_W), .TH_W(TH_W)) u_dq (
    .clk(clk), .rst_n(rst_n), .spike_hit(spike_hit), .center_hit(center_hit),
    .thresh(cfg_dq_thresh), .win_done(win_done), .dq_ok(dq_ok)
  );
endmodule

// File: rtl/crc_clock_recovery_chk.sv
module crc_clock_recovery_chk #(
  parameter int unsigned OSR  = 29,
  parameter int unsigned PH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sample_en,
  input logic            edge_seen,
  input logic            win_done,
  input logic [PH_W-1:0] ph_q,
  input logic            rx_bit,
  input logic            bit_stb,
  input logic            locked,
  input logic            dq_ok
);
  // R2
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n) bit_stb |=> !bit_stb);
  // R2
  stb_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n) bit_stb |-> $past(sample_en));
  // R3
  bit_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n) (rx_bit != $past(rx_bit)) |-> bit_stb);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(rx_bit) && $stable(locked) && !bit_stb));
  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> $past(edge_seen));
  // R7
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(locked) |-> $past(edge_seen));
  // R9
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !win_done |=> $stable(dq_ok));
  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(ph_q) < OSR);
endmodule

bind crc_clock_recovery crc_clock_recovery_chk #(.OSR(OSR), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .edge_seen(edge_seen),
  .win_done(win_done), .ph_q(ph_q), .rx_bit(rx_bit), .bit_stb(bit_stb),
  .locked(locked), .dq_ok(dq_ok)
);

// File: tb/crc_clock_recovery_bench.sv
module crc_clock_recovery_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITLEN = 29;
  // mode, pre bits, odd length, offset bit1, offset bit2, lock before, lock after
  localparam int VEC [8][7] = '{
    '{0, 10, 34, 13, 15, 1, 0},
    '{1, 10, 34, 11, 12, 1, 0},
    '{2, 10, 34, 11, 14, 1, 0},
    '{3,  3, 34, 13, 15, 0, 0},
    '{0, 10, 24, 17, 15, 1, 0},
    '{1, 10, 24, 19, 18, 1, 0},
    '{0, 10, 31, 15, 15, 1, 1},
    '{1, 10, 27, 16, 15, 1, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic raw_in = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [2:0] cfg_dq_thresh = 3'd0;
  logic rx_bit, bit_stb, locked, dq_ok;

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] smp_log = '0;
  int stb_total = 0;
  int bit_pos = 0;
  int first_stb_off = -1;
  logic lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_clock_recovery u_crc_clock_recovery (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .raw_in(raw_in),
    .cfg_mode(cfg_mode), .cfg_dq_thresh(cfg_dq_thresh),
    .rx_bit(rx_bit), .bit_stb(bit_stb), .locked(locked), .dq_ok(dq_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [2:0] th);
    @(negedge clk);
    rst_n = 1'b0; sample_en = 1'b0; raw_in = 1'b0;
    cfg_mode = m; cfg_dq_thresh = th;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    smp_log = '0; stb_total = 0; bit_pos = 0; first_stb_off = -1;
  endtask

  task automatic do_sample(input logic v);
    int want;
    @(negedge clk);
    sample_en = 1'b1; raw_in = v;
    smp_log = {smp_log[1:0], v};
    @(negedge clk);
    sample_en = 1'b0;
    if (bit_stb) begin
      stb_total++;
      if (first_stb_off < 0) first_stb_off = bit_pos;
      want = ($countones(smp_log) >= 2) ? 1 : 0;
      // R3: vote of the last three samples
      check(int'(rx_bit) == want, "R3 centre vote", int'(rx_bit), want);
    end
    bit_pos++;
  endtask

  task automatic send_bit(input logic v, input int len, input int tail);
    first_stb_off = -1;
    bit_pos = 0;
    for (int i = 0; i < len; i++) do_sample((i >= len - tail) ? ~v : v);
  endtask

  task automatic dq_run(input int thr, input int npulse, input int plen, input int exp_ok);
    int b;
    bit seen15;
    string tag;
    tag = (plen >= 7) ? "R8 run of seven" : "R9 window result";
    do_reset(2'd0, 3'(thr));
    seen15 = 1'b0;
    b = 0;
    while (stb_total < 16) begin
      for (int i = 0; i < BITLEN && stb_total < 16; i++) begin
        do_sample((b >= 2 && b < 2 + 2 * npulse && (b % 2) == 0 && i >= BITLEN - plen) ? 1'b0 : 1'b1);
        if (stb_total == 15 && !seen15) begin
          seen15 = 1'b1;
          check(dq_ok == 1'b0, "R9 before window end", int'(dq_ok), 0);
        end
      end
      b++;
    end
    check(int'(dq_ok) == exp_ok, tag, int'(dq_ok), exp_ok);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin : main
    string tag;
    // R1: reset state
    do_reset(2'd0, 3'd0);
    @(negedge clk);
    check({rx_bit, bit_stb, locked, dq_ok} == 4'b0, "R1 reset state",
          int'({rx_bit, bit_stb, locked, dq_ok}), 0);

    // R2: strobe cadence on a flat input
    do_reset(2'd0, 3'd0);
    send_bit(1'b0, 15, 0);
    check(stb_total == 0, "R2 no early strobe", stb_total, 0);
    send_bit(1'b0, 1, 0);
    check(stb_total == 1, "R2 first strobe", stb_total, 1);
    send_bit(1'b0, 28, 0);
    check(stb_total == 1, "R2 interval", stb_total, 1);
    send_bit(1'b0, 1, 0);
    check(stb_total == 2, "R2 second strobe", stb_total, 2);

    // R7: lock on the eighth on-time edge exactly
    do_reset(2'd0, 3'd0);
    lvl = 1'b1;
    for (int b = 0; b < 7; b++) begin
      send_bit(lvl, BITLEN, 0);
      lvl = ~lvl;
    end
    check(locked == 1'b0, "R7 seven edges", int'(locked), 0);
    send_bit(lvl, 1, 0);
    check(locked == 1'b1, "R7 eighth edge", int'(locked), 1);

    // Table: tracking per mode (R4, R5, R6, R7)
    for (int t = 0; t < 8; t++) begin
      tag = (VEC[t][0] == 0) ? "R4 fast step" : (VEC[t][0] == 1) ? "R5 slow step" : "R6 auto step";
      do_reset(2'(VEC[t][0]), 3'd0);
      lvl = 1'b1;
      for (int b = 0; b < VEC[t][1]; b++) begin
        send_bit(lvl, BITLEN, 0);
        lvl = ~lvl;
      end
      check(int'(locked) == VEC[t][5], "R7 lock before", int'(locked), VEC[t][5]);
      send_bit(lvl, VEC[t][2], 0);
      lvl = ~lvl;
      send_bit(lvl, BITLEN, 0);
      lvl = ~lvl;
      check(first_stb_off == VEC[t][3], tag, first_stb_off, VEC[t][3]);
      check(int'(locked) == VEC[t][6], "R7 lock after", int'(locked), VEC[t][6]);
      send_bit(lvl, BITLEN, 0);
      lvl = ~lvl;
      check(first_stb_off == VEC[t][4], tag, first_stb_off, VEC[t][4]);
    end

    // R8, R9: spike length and threshold
    dq_run(0, 0, 6, 1);
    dq_run(0, 1, 7, 1);
    dq_run(0, 1, 6, 0);
    dq_run(2, 2, 6, 1);
    dq_run(2, 3, 6, 0);
    dq_run(7, 3, 6, 1);

    report();
    $finish;
  end
endmodule